// File: doc/BRIEF.md
# Consecutive-Zero Carrier Loss Detector

This block sits on the recovered receive bit stream of a 2.048 Mb/s line. On each rising edge of the receive clock it samples one bit. It counts how many zeros arrive back to back. When that run reaches the threshold chosen by a criteria input, the block declares loss of carrier. The first one that arrives afterwards ends the loss.

The criteria input picks between two thresholds:

| Criteria input | Run of zeros | Duration at 2.048 Mb/s |
|---|---|---|
| 0 | 255 | about 125 µs |
| 1 | 2048 | 1 ms |

Every entry into or exit from loss of carrier sets a sticky change flag. The host clears that flag by pulsing a write-one-to-clear strobe. An active-low interrupt request follows the flag unless a mask input suppresses it.

Top module: `carrier_loss_det`

## Requirements
- R1: While reset is asserted and on its release, `carrier_lost` is 0, `chg_status` is 0 and `irq_n` is 1.
- R2: With `long_crit` = 0, `carrier_lost` goes to 1 on the clock edge that samples the SHORT_RUN-th consecutive zero. It stays 0 after SHORT_RUN-1 zeros.
- R3: With `long_crit` = 1, `carrier_lost` goes to 1 on the clock edge that samples the LONG_RUN-th consecutive zero. It stays 0 after LONG_RUN-1 zeros.
- R4: A sampled one returns the zero-run count to 0. Zeros from before the one never count toward a declaration.
- R5: The zero-run count never exceeds the active threshold. While zeros keep arriving after a declaration, `carrier_lost` stays at 1. The first sampled one clears it on that same edge.
- R6: Each 0-to-1 and each 1-to-0 change of `carrier_lost` sets `chg_status` on the same clock edge.
- R7: When `stat_clr` is 1 on an edge, `chg_status` returns to 0, unless a change of `carrier_lost` happens on that same edge. In that case `chg_status` stays at 1.
- R8: `irq_n` is 0 exactly when `chg_status` is 1 and `irq_mask` is 0. `irq_mask` has no effect on `chg_status`.
- R9: An edge on which `long_crit` differs from its value at the previous edge restarts the zero-run count from 0 and does not count that edge's bit. A change of `long_crit` never by itself changes `carrier_lost`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_data | input | 1 | Recovered NRZ bit, sampled on each rising edge |
| long_crit | input | 1 | Criteria select: 0 uses SHORT_RUN zeros, 1 uses LONG_RUN zeros |
| irq_mask | input | 1 | 1 keeps the change flag off the interrupt request |
| stat_clr | input | 1 | Write-one-to-clear strobe for the change flag |
| carrier_lost | output | 1 | High while loss of carrier is declared |
| chg_status | output | 1 | Sticky flag set on every change of carrier_lost |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The bench builds the block with SHORT_RUN = 12 and LONG_RUN = 40 rather than the default 255 and 2048. Both thresholds, the one-short boundary on each side and the criteria restart then fit in a few dozen cycles per case. With these values a long table of run lengths can be walked for both criteria, with and without masking. The cycle arithmetic of the restart edge, the set-over-clear collision and saturation while loss is held are the same at any threshold. The reduced values therefore reach every path the default build has.

// File: rtl/clp_pkg.sv
package clp_pkg;

  // Transition of the loss-of-carrier state decided on one clock edge
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_SET  = 2'd1,
    EV_CLR  = 2'd2
  } loss_ev_e;

  // Active run-length threshold for a given criteria setting
  function automatic int crit_threshold(input logic long_sel, input int short_n,
                                        input int long_n);
    return long_sel ? long_n : short_n;
  endfunction

  // Next zero-run count: restart on a criteria change or on a one,
  // otherwise count up and hold at the threshold
  function automatic int next_run(input int cur, input logic bit_in,
                                  input logic restart, input int thr);
    if (restart || bit_in) return 0;
    if (cur >= thr) return thr;
    return cur + 1;
  endfunction

  // Event produced by a loss state machine on one edge
  function automatic loss_ev_e loss_event(input logic lost, input logic hit,
                                          input logic bit_in);
    if (!lost && hit) return EV_SET;
    if (lost && bit_in) return EV_CLR;
    return EV_NONE;
  endfunction

endpackage

// File: rtl/clp_run_counter.sv
module clp_run_counter #(
  parameter int SHORT_RUN = 255,
  parameter int LONG_RUN  = 2048,
  parameter int CNT_W     = $clog2(LONG_RUN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_data,
  input  logic             long_crit,
  output logic [CNT_W-1:0] run_cnt,
  output logic             run_hit,
  output logic             crit_chg
);
  import clp_pkg::*;

  logic crit_q;
  int   thr;
  int   cnt_nxt;

  assign crit_chg = crit_q ^ long_crit;
  assign thr      = crit_threshold(long_crit, SHORT_RUN, LONG_RUN);
  assign cnt_nxt  = next_run(int'(run_cnt), rx_data, crit_chg, thr);
  // This edge completes a run of exactly the active threshold
  assign run_hit  = !crit_chg && !rx_data && (int'(run_cnt) == thr - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crit_q  <= 1'b0;
      run_cnt <= '0;
    end else begin
      crit_q  <= long_crit;
      run_cnt <= CNT_W'(cnt_nxt);
    end
  end

endmodule

// File: rtl/clp_loss_state.sv
module clp_loss_state (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_data,
  input  logic run_hit,
  output logic carrier_lost,
  output logic change_ev
);
  import clp_pkg::*;

  loss_ev_e ev;

  assign ev        = loss_event(carrier_lost, run_hit, rx_data);
  assign change_ev = (ev != EV_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carrier_lost <= 1'b0;
    end else begin
      case (ev)
        EV_SET:  carrier_lost <= 1'b1;
        EV_CLR:  carrier_lost <= 1'b0;
        default: carrier_lost <= carrier_lost;
      endcase
    end
  end

endmodule

// File: rtl/clp_change_latch.sv
module clp_change_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic change_ev,
  input  logic stat_clr,
  input  logic irq_mask,
  output logic chg_status,
  output logic irq_n
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_status <= 1'b0;
    end else if (change_ev) begin
      chg_status <= 1'b1;
    end else if (stat_clr) begin
      chg_status <= 1'b0;
    end
  end

  assign irq_n = ~(chg_status & ~irq_mask);

endmodule

// File: rtl/carrier_loss_det.sv
module carrier_loss_det #(
  parameter int SHORT_RUN = 255,
  parameter int LONG_RUN  = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_data,
  input  logic long_crit,
  input  logic irq_mask,
  input  logic stat_clr,
  output logic carrier_lost,
  output logic chg_status,
  output logic irq_n
);
  localparam int CNT_W = $clog2(LONG_RUN + 1);

  logic [CNT_W-1:0] run_cnt;
  logic             run_hit;
  logic             crit_chg;
  logic             change_ev;

  clp_run_counter #(
    .SHORT_RUN(SHORT_RUN),
    .LONG_RUN (LONG_RUN),
    .CNT_W    (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_data  (rx_data),
    .long_crit(long_crit),
    .run_cnt  (run_cnt),
    .run_hit  (run_hit),
    .crit_chg (crit_chg)
  );

  clp_loss_state u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_data     (rx_data),
    .run_hit     (run_hit),
    .carrier_lost(carrier_lost),
    .change_ev   (change_ev)
  );

  clp_change_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .change_ev (change_ev),
    .stat_clr  (stat_clr),
    .irq_mask  (irq_mask),
    .chg_status(chg_status),
    .irq_n     (irq_n)
  );

endmodule

// File: rtl/carrier_loss_det_chk.sv
module carrier_loss_det_chk #(
  parameter int LONG_RUN = 2048,
  parameter int CNT_W    = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_data,
  input logic             long_crit,
  input logic             stat_clr,
  input logic             carrier_lost,
  input logic             chg_status,
  input logic             change_ev,
  input logic [CNT_W-1:0] run_cnt
);

  assert_one_clears_loss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_data |=> !carrier_lost);

  assert_count_saturates_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(run_cnt) <= LONG_RUN);

  assert_one_restarts_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_data |=> (run_cnt == '0));

  assert_change_sets_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (carrier_lost != $past(carrier_lost)) |-> chg_status);

  assert_clear_without_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !change_ev) |=> !chg_status);

  assert_crit_change_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (long_crit != $past(long_crit)) |=> (run_cnt == '0));

  assert_crit_change_no_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((long_crit != $past(long_crit)) && !rx_data) |=> $stable(carrier_lost));

endmodule

bind carrier_loss_det carrier_loss_det_chk #(
  .LONG_RUN(LONG_RUN),
  .CNT_W   (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_data     (rx_data),
  .long_crit   (long_crit),
  .stat_clr    (stat_clr),
  .carrier_lost(carrier_lost),
  .chg_status  (chg_status),
  .change_ev   (change_ev),
  .run_cnt     (run_cnt)
);

// File: tb/tb_carrier_loss_det.sv
module tb_carrier_loss_det;
  localparam int PER = 10;
  localparam int SR  = 12;
  localparam int LR  = 40;
  localparam int NV  = 12;

  // [11] long_crit, [10:3] zeros applied, [2] irq_mask, [1] expected loss, [0] expected irq_n
  localparam logic [11:0] VECS [NV] = '{
    {1'b0, 8'd11, 1'b0, 1'b0, 1'b1},  // R2 one short
    {1'b0, 8'd12, 1'b0, 1'b1, 1'b0},  // R2 exact
    {1'b0, 8'd30, 1'b0, 1'b1, 1'b0},  // R2 beyond
    {1'b0, 8'd1,  1'b0, 1'b0, 1'b1},
    {1'b1, 8'd12, 1'b0, 1'b0, 1'b1},  // R3 short count ignored
    {1'b1, 8'd39, 1'b0, 1'b0, 1'b1},  // R3 one short
    {1'b1, 8'd40, 1'b0, 1'b1, 1'b0},  // R3 exact
    {1'b1, 8'd70, 1'b0, 1'b1, 1'b0},  // R3 beyond
    {1'b0, 8'd12, 1'b1, 1'b1, 1'b1},  // R8 masked
    {1'b1, 8'd40, 1'b1, 1'b1, 1'b1},  // R8 masked
    {1'b1, 8'd0,  1'b0, 1'b0, 1'b1},
    {1'b0, 8'd0,  1'b1, 1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_data = 1'b1;
  logic long_crit = 1'b0;
  logic irq_mask = 1'b0;
  logic stat_clr = 1'b0;
  logic carrier_lost, chg_status, irq_n;
  int   n_vec = 0;
  int   n_bad = 0;

  always #(PER / 2) clk = ~clk;

  carrier_loss_det #(.SHORT_RUN(SR), .LONG_RUN(LR)) dut (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .long_crit(long_crit),
    .irq_mask(irq_mask), .stat_clr(stat_clr), .carrier_lost(carrier_lost),
    .chg_status(chg_status), .irq_n(irq_n)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a falling edge: drive, then let one rising edge consume it
  task automatic cyc(input logic bit_in, input logic clr);
    rx_data  = bit_in;
    stat_clr = clr;
    @(negedge clk);
  endtask

  task automatic zeros(input int n);
    for (int k = 0; k < n; k++) cyc(1'b0, 1'b0);
  endtask

  task automatic restart_clean();
    cyc(1'b1, 1'b0);
    cyc(1'b1, 1'b1);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(PER * 150000);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 lost in reset", carrier_lost, 1'b0);
    check("R1 status in reset", chg_status, 1'b0);
    check("R1 irq in reset", irq_n, 1'b1);
    rst_n = 1'b1;
    cyc(1'b1, 1'b0);
    check("R1 lost after release", carrier_lost, 1'b0);
    check("R1 irq after release", irq_n, 1'b1);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      long_crit = VECS[i][11];
      irq_mask  = VECS[i][2];
      restart_clean();
      zeros(int'(VECS[i][10:3]));
      check(VECS[i][11] ? "R3 loss vs run" : "R2 loss vs run", carrier_lost, VECS[i][1]);
      check("R8 irq vs table", irq_n, VECS[i][0]);
      check("R6 status follows declaration", chg_status, VECS[i][1]);
    end

    // R4: a one in the middle of a run
    long_crit = 1'b0;
    irq_mask  = 1'b0;
    restart_clean();
    zeros(SR - 1);
    cyc(1'b1, 1'b0);
    zeros(SR - 1);
    check("R4 interrupted run", carrier_lost, 1'b0);
    zeros(1);
    check("R4 fresh full run", carrier_lost, 1'b1);

    // R5: held during long zero run, no further event after clear
    zeros(30);
    check("R5 held while zeros", carrier_lost, 1'b1);
    cyc(1'b0, 1'b1);
    check("R7 clear with no event", chg_status, 1'b0);
    zeros(5);
    check("R5 no repeat event", chg_status, 1'b0);
    check("R5 irq idle while held", irq_n, 1'b1);
    cyc(1'b1, 1'b0);
    check("R5 first one clears", carrier_lost, 1'b0);
    check("R6 clear transition flags", chg_status, 1'b1);
    check("R8 irq on clear transition", irq_n, 1'b0);

    // R7: set wins over clear on the same edge
    cyc(1'b1, 1'b1);
    check("R7 cleared", chg_status, 1'b0);
    zeros(SR - 1);
    cyc(1'b0, 1'b1);
    check("R7 collision lost", carrier_lost, 1'b1);
    check("R7 set wins over clear", chg_status, 1'b1);

    // R8: mask gates only the request
    irq_mask = 1'b1;
    cyc(1'b0, 1'b0);
    check("R8 masked irq", irq_n, 1'b1);
    check("R8 mask keeps status", chg_status, 1'b1);
    irq_mask = 1'b0;
    cyc(1'b0, 1'b0);
    check("R8 unmasked irq", irq_n, 1'b0);

    // R9: switch short -> long mid-run restarts the count
    long_crit = 1'b0;
    restart_clean();
    zeros(10);
    long_crit = 1'b1;
    zeros(LR);
    check("R9 switch edge not counted", carrier_lost, 1'b0);
    check("R9 no false event", chg_status, 1'b0);
    zeros(1);
    check("R9 long run after restart", carrier_lost, 1'b1);

    // R9: switch while loss held keeps it with no event
    cyc(1'b0, 1'b1);
    long_crit = 1'b0;
    cyc(1'b0, 1'b0);
    check("R9 held across switch", carrier_lost, 1'b1);
    check("R9 no event on switch", chg_status, 1'b0);

    // R9: switch long -> short mid-run
    long_crit = 1'b1;
    restart_clean();
    zeros(30);
    long_crit = 1'b0;
    zeros(SR);
    check("R9 short after restart, one short", carrier_lost, 1'b0);
    zeros(1);
    check("R9 short after restart, exact", carrier_lost, 1'b1);

    // R1: reset mid-loss
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset drops loss", carrier_lost, 1'b0);
    check("R1 reset drops status", chg_status, 1'b0);
    rst_n = 1'b1;

    finish_run();
  end

endmodule